// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Channel

This block is one DMA channel that copies memory to memory under the control of a chain of descriptors held in memory. Software writes the address of the first descriptor and sets the enable bit. A write to the doorbell register then starts the channel. The channel reads each 32-byte descriptor as eight words and checks its valid flag. It copies the requested number of bytes in units of byte, halfword or word. After the copy it can write a status word, it can clear the valid flag of the finished descriptor, and it then moves on to the next descriptor named by the link field.

A descriptor whose valid flag is clear halts the channel. The channel then stays idle until the doorbell is written again, and it resumes from the same descriptor. Every completion sets a pending flag. An enable bit in the descriptor decides whether that completion also raises the interrupt line. A word-wide memory master port with a request/ready handshake carries every descriptor read, data beat and write-back.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset every register reads 0, `mem_req` and `irq` are low. Register select codes: 0 config (bit 0 enable), 1 descriptor pointer, 2 status pointer, 3 doorbell, 4 pending (bit 0), 5 channel status, 6 remaining byte count.
- R2: A doorbell write while the channel is enabled and idle makes it fetch the descriptor at the descriptor pointer. Channel status bit 2 records the doorbell and bit 1 is set while a valid descriptor is being worked.
- R3: A descriptor whose word 0 bit 31 is clear sets status bit 0 (halted) and clears bit 2, and the channel issues no further memory requests with the pointer left unchanged. A later doorbell refetches that same address.
- R4: The copy unit is the narrower of the source width (word 0 bits 19:18) and destination width (bits 17:16), where 0 is byte, 1 is halfword and 2 or 3 is word. The copy moves exactly the byte count in word 1 bits 21:0 from the address in word 2 to the address in word 4. Byte lane n of a memory word holds address offset n, and bytes outside the destination range are unchanged.
- R5: A byte count of 0 produces no data beats, but the descriptor still completes.
- R6: Word 0 bits 1:0 select the write-back: 0 writes nothing, 1 writes channel status {doorbell, valid, halted} in bits 2:0, 2 writes word 0 with bit 31 cleared, and 3 writes the remaining byte count. Word 0 bit 4 set sends the write to the status pointer; clear sends it to descriptor word 6 (offset 24).
- R7: With word 0 bit 2 set, word 0 of the finished descriptor is rewritten with bit 31 cleared. A chain that comes back to that descriptor then halts.
- R8: On completion the descriptor pointer becomes word 7 bits 26:0 shifted left by 5, and that descriptor is fetched next while enabled.
- R9: Pending bit 0 is set on every completion. Writing 1 to it clears it, and a completion in the same cycle as that write leaves it set.
- R10: `irq` rises on a completion only when word 0 bit 8 is set, and it falls when pending is cleared.
- R11: Clearing the enable bit lets the current memory beat finish and then idles the channel, with no completion and no further fetch. Register 6 then gives the bytes not yet written.
- R12: A memory beat completes in a cycle with `mem_req` and `mem_rdy` both high. Until then the address, direction and write data are held.
- R13: `done` is a one-cycle pulse per completed descriptor, issued after its write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Memory accepts the beat |
| irq | output | 1 | Interrupt request |
| done | output | 1 | Descriptor completion pulse |

## Verification
Two functions can meet in one cycle: a descriptor completing sets the pending bit while software writes 1 to clear it. The bench waits until it sees `done` high away from the clock edge. It then drives the clearing write so that the write lands on the same rising edge as the completion. The bench judges the outcome by reading the pending bit and `irq` afterwards: both must still be set, and a second clear must drop them.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rdy,
  output logic              irq,
  output logic              done
);
  localparam int NXT_W = ADDR_W - 5;
  localparam logic [2:0] SEL_CFG  = 3'd0;
  localparam logic [2:0] SEL_DESC = 3'd1;
  localparam logic [2:0] SEL_SPTR = 3'd2;
  localparam logic [2:0] SEL_BELL = 3'd3;
  localparam logic [2:0] SEL_PEND = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;
  localparam logic [2:0] SEL_CNT  = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_STAT, S_CLRV, S_NEXT} st_t;

  st_t               state;
  logic [2:0]        idx;
  logic              en, db, vld, halt, pend, irq_q;
  logic [ADDR_W-1:0] desc_ptr, stat_ptr, src, dst;
  logic [31:0]       cmd0, dbuf;
  logic [NXT_W-1:0]  nxt;
  logic [CNT_W-1:0]  rem;

  wire       beat  = mem_req && mem_rdy;
  wire       bell  = reg_wr && (reg_sel == SEL_BELL);
  wire [1:0] wsel  = (cmd0[19:18] < cmd0[17:16]) ? cmd0[19:18] : cmd0[17:16];
  wire [2:0] unit  = (wsel >= 2'd2) ? 3'd4 : ((wsel == 2'd1) ? 3'd2 : 3'd1);
  wire [3:0] umask = (wsel >= 2'd2) ? 4'hF : ((wsel == 2'd1) ? 4'h3 : 4'h1);
  wire       last  = rem <= CNT_W'(unit);
  wire [2:0] chan_stat = {db, vld, halt};
  wire [31:0] lane_data = (dbuf >> {src[1:0], 3'b000}) << {dst[1:0], 3'b000};

  st_t after_copy;
  assign after_copy = (cmd0[1:0] != 2'd0) ? S_STAT : (cmd0[2] ? S_CLRV : S_NEXT);

  logic [31:0] stat_word;
  always_comb begin
    case (cmd0[1:0])
      2'd1:    stat_word = {29'd0, chan_stat};
      2'd2:    stat_word = {1'b0, cmd0[30:0]};
      2'd3:    stat_word = 32'(rem);
      default: stat_word = '0;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 4'hF;
    mem_wdata = '0;
    case (state)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_ptr + ADDR_W'({idx, 2'b00});
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = {src[ADDR_W-1:2], 2'b00};
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {dst[ADDR_W-1:2], 2'b00};
        mem_be    = umask << dst[1:0];
        mem_wdata = lane_data;
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cmd0[4] ? stat_ptr : desc_ptr + ADDR_W'(24);
        mem_wdata = stat_word;
      end
      S_CLRV: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr;
        mem_wdata = {1'b0, cmd0[30:0]};
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_sel)
      SEL_CFG:  reg_rdata = {31'd0, en};
      SEL_DESC: reg_rdata = 32'(desc_ptr);
      SEL_SPTR: reg_rdata = 32'(stat_ptr);
      SEL_PEND: reg_rdata = {31'd0, pend};
      SEL_STAT: reg_rdata = {29'd0, chan_stat};
      SEL_CNT:  reg_rdata = 32'(rem);
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      en       <= 1'b0;
      db       <= 1'b0;
      vld      <= 1'b0;
      halt     <= 1'b0;
      pend     <= 1'b0;
      irq_q    <= 1'b0;
      desc_ptr <= '0;
      stat_ptr <= '0;
      src      <= '0;
      dst      <= '0;
      cmd0     <= '0;
      dbuf     <= '0;
      nxt      <= '0;
      rem      <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_sel)
          SEL_CFG:  en       <= reg_wdata[0];
          SEL_DESC: desc_ptr <= {reg_wdata[ADDR_W-1:5], 5'd0};
          SEL_SPTR: stat_ptr <= {reg_wdata[ADDR_W-1:2], 2'd0};
          SEL_BELL: begin
            db   <= 1'b1;
            halt <= 1'b0;
          end
          SEL_PEND: if (reg_wdata[0]) begin
            pend  <= 1'b0;
            irq_q <= 1'b0;
          end
          default: ;
        endcase
      end
      case (state)
        S_IDLE: if (bell && en) begin
          state <= S_FETCH;
          idx   <= '0;
        end
        S_FETCH: if (beat) begin
          idx <= idx + 3'd1;
          case (idx)
            3'd0: cmd0 <= mem_rdata;
            3'd1: rem  <= mem_rdata[CNT_W-1:0];
            3'd2: src  <= mem_rdata[ADDR_W-1:0];
            3'd4: dst  <= mem_rdata[ADDR_W-1:0];
            3'd7: nxt  <= mem_rdata[NXT_W-1:0];
            default: ;
          endcase
          if (idx == 3'd0 && !mem_rdata[31]) begin
            halt  <= 1'b1;
            db    <= 1'b0;
            vld   <= 1'b0;
            state <= S_IDLE;
          end else if (!en) begin
            state <= S_IDLE;
          end else if (idx == 3'd7) begin
            vld   <= 1'b1;
            state <= (rem == '0) ? after_copy : S_RD;
          end
        end
        S_RD: if (beat) begin
          dbuf  <= mem_rdata;
          state <= en ? S_WR : S_IDLE;
        end
        S_WR: if (beat) begin
          src   <= src + ADDR_W'(unit);
          dst   <= dst + ADDR_W'(unit);
          rem   <= last ? '0 : rem - CNT_W'(unit);
          state <= !en ? S_IDLE : (last ? after_copy : S_RD);
        end
        S_STAT: if (beat) state <= cmd0[2] ? S_CLRV : S_NEXT;
        S_CLRV: if (beat) state <= S_NEXT;
        S_NEXT: begin
          pend     <= 1'b1;
          if (cmd0[8]) irq_q <= 1'b1;
          vld      <= 1'b0;
          desc_ptr <= {nxt, 5'd0};
          idx      <= '0;
          state    <= en ? S_FETCH : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done = (state == S_NEXT);
  assign irq  = irq_q;
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_rdy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          done,
  input logic          irq,
  input logic          pend,
  input logic          halt
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pend);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done));

  // R10
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  // R3
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_req);
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.AW(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .irq(irq),
  .pend(pend), .halt(halt)
);

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] R_CFG = 3'd0, R_DESC = 3'd1, R_SPTR = 3'd2, R_BELL = 3'd3,
                         R_PEND = 3'd4, R_STAT = 3'd5, R_CNT = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        irq, done;

  logic [31:0] mem [256];
  logic [31:0] img [256];
  int n_tests = 0, n_fail = 0, ndone = 0, viol = 0;
  logic [7:0]  lfsr = 8'hA1;
  logic        hold_chk = 1'b0, hold_we = 1'b0;
  logic [31:0] hold_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .irq(irq), .done(done)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_rdy && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  initial mem_rdy = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done) ndone++;
    if (hold_chk && (!mem_req || mem_addr !== hold_addr || mem_we !== hold_we)) viol++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy = lfsr[0] | lfsr[2];
    hold_chk = mem_req && !mem_rdy;
    hold_addr = mem_addr;
    hold_we = mem_we;
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(int a);
    logic [31:0] w;
    w = mem[(a >> 2) & 255];
    return w[8*(a & 3) +: 8];
  endfunction

  function automatic logic [7:0] ib(int a);
    logic [31:0] w;
    w = img[(a >> 2) & 255];
    return w[8*(a & 3) +: 8];
  endfunction

  function automatic logic [31:0] mk(logic [1:0] w, logic ie, logic sp, logic cv, logic [1:0] st);
    return {1'b1, 1'b1, 5'd31, 5'd31, w, w, 7'd0, ie, 3'd0, sp, 1'b0, cv, st};
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++)
      mem[i] = {i[7:0] ^ 8'h5A, 8'(i * 7), ~i[7:0], i[7:0] + 8'd3};
  endtask

  task automatic snap();
    for (int i = 0; i < 256; i++) img[i] = mem[i];
  endtask

  task automatic put_desc(int a, logic [31:0] c0, int bc, int s, int d, int nx);
    mem[a/4 + 0] = c0;
    mem[a/4 + 1] = bc;
    mem[a/4 + 2] = s;
    mem[a/4 + 3] = 0;
    mem[a/4 + 4] = d;
    mem[a/4 + 5] = 0;
    mem[a/4 + 6] = 32'hDEAD0000 | a;
    mem[a/4 + 7] = nx >> 5;
  endtask

  task automatic reg_write(logic [2:0] sel, logic [31:0] data);
    reg_wr = 1'b1;
    reg_sel = sel;
    reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] sel, output logic [31:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic wait_idle(string req);
    int q = 0;
    int g = 0;
    while (q < 10 && g < 20000) begin
      @(negedge clk);
      g++;
      q = mem_req ? 0 : q + 1;
    end
    if (g >= 20000) check(req, "channel never went idle", 32'd1, 32'd0);
  endtask

  task automatic check_copy(string req, int s, int d, int n);
    int bad = 0;
    for (int k = 0; k < n; k++) if (mb(d + k) !== ib(s + k)) bad++;
    check(req, "copied bytes mismatching", bad, 0);
    check(req, "byte after destination", mb(d + n), ib(d + n));
    check(req, "byte before destination", mb(d - 1), ib(d - 1));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(R_STAT, v); check("R1", "status after reset", v, 0);
    reg_read(R_PEND, v); check("R1", "pending after reset", v, 0);
    reg_read(R_DESC, v); check("R1", "desc ptr after reset", v, 0);
    reg_read(R_CNT, v);  check("R1", "count after reset", v, 0);
    check("R1", "irq after reset", irq, 0);
    check("R1", "mem_req after reset", mem_req, 0);
  endtask

  task automatic t_word_copy();
    logic [31:0] v;
    int d0;
    init_mem();
    put_desc(32'h100, mk(2'd2, 1'b1, 1'b0, 1'b0, 2'd1), 16, 32'h200, 32'h280, 32'h140);
    mem[32'h140/4] = 0;
    snap();
    reg_write(R_DESC, 32'h100);
    reg_write(R_CFG, 1);
    d0 = ndone;
    reg_write(R_BELL, 1);
    wait_idle("R4");
    check_copy("R4", 32'h200, 32'h280, 16);
    check("R2", "status write doorbell+valid", mem[32'h118/4], 32'd6);
    reg_read(R_STAT, v); check("R3", "status after invalid descriptor", v, 32'd1);
    reg_read(R_DESC, v); check("R8", "pointer follows link", v, 32'h140);
    reg_read(R_PEND, v); check("R9", "pending after completion", v, 1);
    check("R10", "irq with enable bit", irq, 1);
    check("R13", "done pulses", ndone - d0, 1);
  endtask

  task automatic t_byte_copy();
    logic [31:0] v;
    reg_write(R_PEND, 1);
    check("R10", "irq after clear", irq, 0);
    init_mem();
    put_desc(32'h100, mk(2'd0, 1'b0, 1'b1, 1'b0, 2'd3), 5, 32'h241, 32'h2C3, 32'h140);
    mem[32'h140/4] = 0;
    mem[32'h300/4] = 32'hFFFFFFFF;
    snap();
    reg_write(R_SPTR, 32'h300);
    reg_write(R_DESC, 32'h100);
    reg_write(R_BELL, 1);
    wait_idle("R4");
    check_copy("R4", 32'h241, 32'h2C3, 5);
    check("R6", "count write at status pointer", mem[32'h300/4], 0);
    check("R6", "own status word untouched", mem[32'h118/4], img[32'h118/4]);
    reg_read(R_PEND, v); check("R9", "pending without irq enable", v, 1);
    check("R10", "no irq without enable", irq, 0);
  endtask

  task automatic t_half_clear_valid();
    logic [31:0] v, c0;
    int d0;
    reg_write(R_PEND, 1);
    init_mem();
    c0 = mk(2'd1, 1'b0, 1'b0, 1'b1, 2'd2);
    put_desc(32'h180, c0, 6, 32'h220, 32'h2A2, 32'h180);
    snap();
    reg_write(R_DESC, 32'h180);
    d0 = ndone;
    reg_write(R_BELL, 1);
    wait_idle("R7");
    check_copy("R4", 32'h220, 32'h2A2, 6);
    check("R6", "cmd0 copy in own status word", mem[32'h198/4], c0 & 32'h7FFFFFFF);
    check("R7", "valid cleared in descriptor", mem[32'h180/4], c0 & 32'h7FFFFFFF);
    reg_read(R_STAT, v); check("R7", "wrapped chain halts", v, 32'd1);
    reg_read(R_DESC, v); check("R8", "self link pointer", v, 32'h180);
    check("R13", "one completion", ndone - d0, 1);
  endtask

  task automatic t_chain_zero();
    logic [31:0] v;
    int d0;
    init_mem();
    put_desc(32'h100, mk(2'd2, 1'b0, 1'b0, 1'b0, 2'd0), 8, 32'h200, 32'h280, 32'h120);
    put_desc(32'h120, mk(2'd2, 1'b0, 1'b0, 1'b0, 2'd1), 0, 32'h210, 32'h290, 32'h140);
    mem[32'h140/4] = 0;
    snap();
    reg_write(R_DESC, 32'h100);
    d0 = ndone;
    reg_write(R_BELL, 1);
    wait_idle("R8");
    check_copy("R4", 32'h200, 32'h280, 8);
    check("R5", "zero-length destination untouched", mem[32'h290/4], img[32'h290/4]);
    check("R5", "zero-length still writes status", mem[32'h138/4], 32'd6);
    check("R6", "no write-back when action 0", mem[32'h118/4], img[32'h118/4]);
    check("R8", "two completions in chain", ndone - d0, 2);
    reg_read(R_DESC, v); check("R8", "pointer at chain end", v, 32'h140);
    put_desc(32'h140, mk(2'd2, 1'b0, 1'b0, 1'b0, 2'd0), 4, 32'h230, 32'h2B0, 32'h160);
    mem[32'h160/4] = 0;
    snap();
    d0 = ndone;
    reg_write(R_BELL, 1);
    wait_idle("R3");
    check_copy("R3", 32'h230, 32'h2B0, 4);
    reg_read(R_DESC, v); check("R3", "resume from halted pointer", v, 32'h160);
    check("R3", "resume completion", ndone - d0, 1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    int g = 0;
    reg_write(R_PEND, 1);
    init_mem();
    put_desc(32'h100, mk(2'd2, 1'b1, 1'b0, 1'b0, 2'd0), 8, 32'h200, 32'h280, 32'h140);
    mem[32'h140/4] = 0;
    snap();
    reg_write(R_DESC, 32'h100);
    reg_write(R_BELL, 1);
    while (!done && g < 5000) begin @(negedge clk); g++; end
    check("R9", "completion seen", done, 1);
    reg_write(R_PEND, 1);
    wait_idle("R9");
    reg_read(R_PEND, v); check("R9", "set wins over clear", v, 1);
    check("R10", "irq kept on collision", irq, 1);
    reg_write(R_PEND, 1);
    reg_read(R_PEND, v); check("R9", "clear by writing 1", v, 0);
    check("R10", "irq drops with pending", irq, 0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    int d0, n;
    init_mem();
    put_desc(32'h100, mk(2'd0, 1'b0, 1'b0, 1'b0, 2'd0), 128, 32'h200, 32'h300, 32'h140);
    mem[32'h140/4] = 0;
    snap();
    reg_write(R_CFG, 1);
    reg_write(R_DESC, 32'h100);
    d0 = ndone;
    reg_write(R_BELL, 1);
    repeat (40) @(negedge clk);
    reg_write(R_CFG, 0);
    wait_idle("R11");
    reg_read(R_CNT, v);
    check("R11", "stopped mid-copy", (v > 0 && v < 128) ? 1 : 0, 1);
    n = 128 - int'(v);
    check_copy("R11", 32'h200, 32'h300, n);
    check("R11", "no completion when disabled", ndone - d0, 0);
    reg_read(R_DESC, v); check("R11", "no further fetch", v, 32'h100);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_word_copy();
    t_byte_copy();
    t_half_clear_valid();
    t_chain_zero();
    t_collide();
    t_disable();
    check("R12", "handshake hold violations", viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule